// File: doc/BRIEF.md
# Byte-Addressed Serial Target with Row-Wrapping Write Pointer

This block is the target side of a two-wire serial bus (I2C). It watches SCL and SDA, which are already sampled into the system clock domain. It recognises start, repeated start and stop conditions, and it moves bytes most significant bit first. It acknowledges by pulling SDA low. It never holds SCL low.

A write transaction carries two kinds of byte after the target's address. The first byte after the address loads an 8-bit pointer. Every byte after that becomes a one-cycle write strobe on a byte-wide memory port. A read transaction sends the bytes found at the pointer's current value. The pointer behaves differently in the two directions. When writing, it advances only inside the current 8-byte row. When reading, it runs through the full 256-byte space and rolls over from FFh to 00h.

A stop that ends a transaction in which data was written raises a single-cycle commit event, which can start a slow nonvolatile save. While the `busy_i` input is high, the block refuses its own address, so a master can poll until the save has finished.

Top module: `i2c_paged_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0), no write strobe or commit event is raised, and the pointer reads 00h on `mem_addr_o`.
- R2: The first byte after a start is compared, in bits 7..1, with the address 1,0,1,0,0,0 followed by `addr_sel_i`. Bit 0 selects read (1) or write (0). On a match the block drives SDA low for the ninth clock. On a mismatch it leaves SDA high and ignores all traffic until the next start.
- R3: While `busy_i` is high during the address byte, the block does not acknowledge its address, even when the address matches.
- R4: In a write transaction, the byte after the address byte is loaded into the pointer and appears on `mem_addr_o`.
- R5: Each later write byte is acknowledged and produces a one-cycle `mem_we_o` with the pointer on `mem_addr_o` and the byte on `mem_wdata_o`. The pointer then advances in its low 3 bits only, so bytes written from 06h land at 06h, 07h and 00h.
- R6: A read sends the byte at the current pointer first and advances the pointer by one after each byte is loaded, crossing row boundaries and rolling over from FFh to 00h. Bits change only while SCL is low.
- R7: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more. SDA is also released after any stop.
- R8: `commit_o` pulses for one cycle after a stop only if at least one data byte was written since the previous stop. An address-only write and a read raise no commit.
- R9: A repeated start returns the block to the address phase without a stop, and the pointer keeps the value set earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled serial clock level |
| sda_i | input | 1 | Sampled serial data level (wired bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Least significant bit of the target address |
| busy_i | input | 1 | 1 refuses the target address |
| mem_addr_o | output | 8 | Pointer value, used for reads and writes |
| mem_rdata_i | input | 8 | Byte stored at `mem_addr_o` (combinational read) |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | One-cycle write strobe |
| commit_o | output | 1 | One-cycle event after a stop that ends a write with data |

## Verification
Two pointer updates fall in the same cycle as other work:

- **Read reload.** The SCL falling edge that closes the master's acknowledge slot both loads the next read byte and advances the pointer. The byte fetched and the increment therefore land in one cycle.
- **Write strobe.** In a write, the strobe cycle is also the cycle in which the pointer steps inside its row.

The bench provokes these cases in three ways. It runs multi-byte reads that cross a row edge and the FFh-to-00h rollover. It runs writes that start near the end of a row. It follows each read with a current-address read. Every read byte is judged against a bench memory model. Every strobe is compared on each clock with a queue of expected address/data pairs.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    ROLE_DEV,
    ROLE_MADDR,
    ROLE_DATA
  } rx_role_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL stays high marks a start (falling) or a stop (rising)
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_row_counter.sv
module i2c_row_counter #(
  parameter int AW       = 8,
  parameter int ROW_BITS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_row_i,
  input  logic          inc_lin_i,
  output logic [AW-1:0] ctr_o
);
  logic [AW-1:0] ctr_q, ctr_d;
  logic          ctr_en;

  always_comb begin
    ctr_d = ctr_q;
    if (load_i)
      ctr_d = load_val_i;
    else if (inc_row_i)
      ctr_d = {ctr_q[AW-1:ROW_BITS], ctr_q[ROW_BITS-1:0] + ROW_BITS'(1)};
    else if (inc_lin_i)
      ctr_d = ctr_q + AW'(1);
  end

  assign ctr_en = load_i | inc_row_i | inc_lin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctr_q <= '0;
    else if (ctr_en) ctr_q <= ctr_d;
  end

  assign ctr_o = ctr_q;
endmodule

// File: rtl/i2c_paged_target.sv
module i2c_paged_target
  import i2c_tgt_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter int          ROW_BITS = 3,
  parameter logic [5:0]  DEV_HI   = 6'b101000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          addr_sel_i,
  input  logic          busy_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          commit_o
);
  localparam int BIT_CW = $clog2(DW + 1);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DW - 1);
  localparam logic [BIT_CW-1:0] FULL_CNT = BIT_CW'(DW);

  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  tgt_state_e        state_q, state_d;
  rx_role_e          role_q, role_d;
  logic [BIT_CW-1:0] bitcnt_q, bitcnt_d;
  logic [DW-1:0]     shreg_q, shreg_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic              ack_q, ack_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              wrote_q, wrote_d;
  logic              we_q, we_d;
  logic              commit_q, commit_d;
  logic              ctr_load, ctr_inc_lin;
  logic [DW-1:0]     rx_byte;
  logic [AW-1:0]     ptr;

  assign rx_byte = {shreg_q[DW-2:0], sda_i};

  i2c_row_counter #(.AW(AW), .ROW_BITS(ROW_BITS)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ctr_load),
    .load_val_i(rx_byte[AW-1:0]),
    .inc_row_i (we_q),
    .inc_lin_i (ctr_inc_lin),
    .ctr_o     (ptr)
  );

  always_comb begin
    state_d     = state_q;
    role_d      = role_q;
    bitcnt_d    = bitcnt_q;
    shreg_d     = shreg_q;
    wdata_d     = wdata_q;
    ack_d       = ack_q;
    rw_d        = rw_q;
    mack_d      = mack_q;
    wrote_d     = wrote_q;
    we_d        = 1'b0;
    commit_d    = 1'b0;
    ctr_load    = 1'b0;
    ctr_inc_lin = 1'b0;
    if (stop_det) begin
      state_d  = ST_IDLE;
      commit_d = wrote_q;
      wrote_d  = 1'b0;
    end else if (start_det) begin
      state_d  = ST_RX;
      role_d   = ROLE_DEV;
      bitcnt_d = '0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_d  = rx_byte;
            bitcnt_d = bitcnt_q + BIT_CW'(1);
            if (bitcnt_q == LAST_BIT) begin
              case (role_q)
                ROLE_DEV: begin
                  ack_d = (rx_byte[DW-1:1] == {DEV_HI, addr_sel_i}) && !busy_i;
                  rw_d  = rx_byte[0];
                end
                ROLE_MADDR: begin
                  ack_d    = 1'b1;
                  ctr_load = 1'b1;
                end
                default: begin
                  ack_d   = 1'b1;
                  we_d    = 1'b1;
                  wdata_d = rx_byte;
                  wrote_d = 1'b1;
                end
              endcase
            end
          end else if (scl_fall && bitcnt_q == FULL_CNT) begin
            state_d = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (!ack_q) begin
              state_d = ST_IDLE;
            end else if (role_q == ROLE_DEV && rw_q) begin
              state_d     = ST_TX;
              shreg_d     = mem_rdata_i;
              ctr_inc_lin = 1'b1;
            end else begin
              state_d = ST_RX;
              role_d  = (role_q == ROLE_DEV) ? ROLE_MADDR : ROLE_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + BIT_CW'(1);
          end else if (scl_fall) begin
            if (bitcnt_q == FULL_CNT) state_d = ST_TX_ACK;
            else                      shreg_d = {shreg_q[DW-2:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = !sda_i;
          end else if (scl_fall) begin
            bitcnt_d = '0;
            if (mack_q) begin
              state_d     = ST_TX;
              shreg_d     = mem_rdata_i;
              ctr_inc_lin = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      role_q   <= ROLE_DEV;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      wdata_q  <= '0;
      ack_q    <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      wrote_q  <= 1'b0;
      we_q     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      role_q   <= role_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      wdata_q  <= wdata_d;
      ack_q    <= ack_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      wrote_q  <= wrote_d;
      we_q     <= we_d;
      commit_q <= commit_d;
    end
  end

  assign sda_oe_o    = (state_q == ST_RX_ACK && ack_q) ||
                       (state_q == ST_TX && !shreg_q[DW-1]);
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = we_q;
  assign commit_o    = commit_q;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int AW       = 8,
  parameter int ROW_BITS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          commit_o,
  input logic          start_det,
  input logic          stop_det
);
  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (mem_addr_o[AW-1:ROW_BITS] == $past(mem_addr_o[AW-1:ROW_BITS])) &&
                 (mem_addr_o[ROW_BITS-1:0] == $past(mem_addr_o[ROW_BITS-1:0]) + ROW_BITS'(1)));

  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  a_r8_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_det));

  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> (!scl_i || $past(start_det || stop_det)));

  a_r7_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);
endmodule

bind i2c_paged_target i2c_tgt_chk #(.AW(AW), .ROW_BITS(ROW_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .mem_addr_o(mem_addr_o),
  .mem_we_o  (mem_we_o),
  .commit_o  (commit_o),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/test_i2c_paged_target.sv
module test_i2c_paged_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m, addr_sel, busy;
  logic sda_oe, mem_we, commit;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic bus_sda;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int exp_commit = 0;
  logic [7:0] mem_m [256];
  logic [7:0] ref_m [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_sda   = sda_m & ~sda_oe;
  assign mem_rdata = mem_m[mem_addr];

  i2c_paged_target i_i2c_paged_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .busy_i(busy), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .commit_o(commit)
  );

  always @(posedge clk) if (mem_we) mem_m[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison of strobes and commit events
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mem_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", {mem_addr, mem_wdata}, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata} == 16'(e), "R5 write addr/data", {mem_addr, mem_wdata}, e);
        end
      end
      if (commit) begin
        chk(exp_commit > 0, "R8 commit event", 1, exp_commit);
        if (exp_commit > 0) exp_commit--;
      end
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wait_q(Q);
    scl = 1'b1; wait_q(2);
    b = bus_sda; wait_q(2);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    ref_m[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = 8'((i * 7 + 3) & 255);
      ref_m[i] = 8'((i * 7 + 3) & 255);
    end
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; addr_sel = 1'b0; busy = 1'b0;
    wait_q(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(mem_we == 1'b0 && commit == 1'b0, "R1 no strobe/commit", {mem_we, commit}, 0);
    chk(mem_addr == 8'h00, "R1 pointer zero", mem_addr, 0);
    rst_n = 1'b1;
    wait_q(5);

    // R2 R4 R5 R8: row-wrapping write from 06h
    bus_start();
    wr_byte(8'hA0, ak); chk(ak, "R2 address ack", ak, 1);
    wr_byte(8'h06, ak); chk(ak, "R4 pointer byte ack", ak, 1);
    chk(mem_addr == 8'h06, "R4 pointer loaded", mem_addr, 8'h06);
    exp_wr(8'h06, 8'h11); exp_wr(8'h07, 8'h22); exp_wr(8'h00, 8'h33);
    wr_byte(8'h11, ak); chk(ak, "R5 data ack", ak, 1);
    wr_byte(8'h22, ak);
    wr_byte(8'h33, ak);
    chk(mem_addr == 8'h01, "R5 wrapped pointer", mem_addr, 8'h01);
    exp_commit = 1;
    bus_stop(); wait_q(4);
    chk(exp_commit == 0, "R8 commit after write", exp_commit, 0);
    chk(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);

    // R9 R6 R7: dummy write then read across a row edge
    bus_start();
    wr_byte(8'hA0, ak);
    wr_byte(8'h06, ak);
    bus_rstart();
    wr_byte(8'hA1, ak); chk(ak, "R9 read address ack after repeated start", ak, 1);
    rd_byte(d, 1'b0); chk(d == ref_m[8'h06], "R6 read byte 06", d, ref_m[8'h06]);
    rd_byte(d, 1'b0); chk(d == ref_m[8'h07], "R6 read byte 07", d, ref_m[8'h07]);
    rd_byte(d, 1'b1); chk(d == ref_m[8'h08], "R6 read crosses row", d, ref_m[8'h08]);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop(); wait_q(4);
    chk(exp_commit == 0, "R8 no commit for read", exp_commit, 0);

    // R6 rollover FFh to 00h, then current-address read
    bus_start();
    wr_byte(8'hA0, ak);
    wr_byte(8'hFE, ak);
    bus_rstart();
    wr_byte(8'hA1, ak);
    rd_byte(d, 1'b0); chk(d == ref_m[8'hFE], "R6 read FE", d, ref_m[8'hFE]);
    rd_byte(d, 1'b0); chk(d == ref_m[8'hFF], "R6 read FF", d, ref_m[8'hFF]);
    rd_byte(d, 1'b1); chk(d == ref_m[8'h00], "R6 rollover to 00", d, ref_m[8'h00]);
    bus_stop(); wait_q(4);
    bus_start();
    wr_byte(8'hA1, ak);
    rd_byte(d, 1'b1); chk(d == ref_m[8'h01], "R6 current address read", d, ref_m[8'h01]);
    bus_stop(); wait_q(4);

    // R5 wrap near the end of a row
    bus_start();
    wr_byte(8'hA0, ak);
    wr_byte(8'h3D, ak);
    exp_wr(8'h3D, 8'hA1); exp_wr(8'h3E, 8'hA2); exp_wr(8'h3F, 8'hA3); exp_wr(8'h38, 8'hA4);
    wr_byte(8'hA1, ak); wr_byte(8'hA2, ak); wr_byte(8'hA3, ak); wr_byte(8'hA4, ak);
    exp_commit = 1;
    bus_stop(); wait_q(4);
    chk(exp_q.size() == 0 && exp_commit == 0, "R5 row wrap at 38", exp_q.size(), 0);

    // R2 mismatch: select pin high, address A0 refused, later bytes ignored
    addr_sel = 1'b1;
    bus_start();
    wr_byte(8'hA0, ak); chk(!ak, "R2 mismatch nack", ak, 0);
    wr_byte(8'h10, ak); chk(!ak, "R2 ignored byte not acked", ak, 0);
    wr_byte(8'h55, ak);
    bus_stop(); wait_q(4);
    chk(exp_q.size() == 0, "R2 no write after mismatch", exp_q.size(), 0);
    bus_start();
    wr_byte(8'hA2, ak); chk(ak, "R2 match with select high", ak, 1);
    wr_byte(8'h20, ak);
    exp_wr(8'h20, 8'h77);
    wr_byte(8'h77, ak);
    exp_commit = 1;
    bus_stop(); wait_q(4);
    chk(exp_commit == 0, "R8 commit after second write", exp_commit, 0);

    // R3 busy refuses the address
    busy = 1'b1;
    bus_start();
    wr_byte(8'hA2, ak); chk(!ak, "R3 busy nack", ak, 0);
    bus_stop(); wait_q(4);
    busy = 1'b0;

    // R8 address-only write raises no commit
    bus_start();
    wr_byte(8'hA2, ak); chk(ak, "R3 ack once idle", ak, 1);
    wr_byte(8'h10, ak);
    bus_stop(); wait_q(6);
    chk(mem_addr == 8'h10, "R4 pointer from address-only write", mem_addr, 8'h10);
    chk(exp_commit == 0, "R8 no commit without data", exp_commit, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule